// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block keeps the tag and valid state of a set-associative cache without holding any data. A client presents one address per cycle on a valid/ready request port. The block splits the address into a tag, a set index and a byte offset, compares the tag against every way of the indexed set, and installs the block on a miss. One cycle after each accepted request it reports one of three outcomes: the block was already present, it was placed in an empty way, or it displaced a valid block. In the last case it also returns the base address of the displaced block.

The victim choice on a full set is selected per request by a policy input. The policies are: oldest way, newest way, or a repeatable pseudo-random way. The random sequence comes from a 16-bit shift register that is reloaded from a seed input during reset, so a run can be replayed. The cache geometry is fixed by parameters: address width, set-index width, offset width and associativity.

Top module: `cache_tag_dir`

## Requirements
- R1: While `rst` is high, every line of every set becomes invalid, `req_ready` is low and `resp_valid` is low. `req_ready` is high from the first clock edge after `rst` falls.
- R2: Address bits [OFF_BITS-1:0] are the byte offset and are ignored for matching. Bits [OFF_BITS+SET_BITS-1:OFF_BITS] pick the set. All higher bits form the tag.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Exactly one response follows, with `resp_valid` high in the next cycle only. `resp_valid` stays low in any cycle that follows an edge with no accepted request.
- R4: If a valid way of the indexed set holds the request tag, the status is 0 (hit) and no line contents change.
- R5: If there is no hit and some way of the set is invalid, the status is 1 (fill without eviction). The lowest-numbered invalid way receives the tag and becomes valid.
- R6: If there is no hit and all ways are valid, the status is 2 (eviction). The victim way takes the new tag. `resp_evict_addr` equals the victim's old tag, followed by the set index, followed by OFF_BITS zero bits. For status 0 and 1, `resp_evict_addr` is zero. Status 3 never occurs.
- R7: With `cfg_policy` equal to 0 or 3, the victim is the way whose last hit or fill is the oldest in that set.
- R8: With `cfg_policy` equal to 1, the victim is the way whose last hit or fill is the most recent in that set.
- R9: With `cfg_policy` equal to 2, the victim is way (S mod WAYS), where S is the current 16-bit random state. After each such eviction, S shifts left by one and takes bit 15^13^12^10 of its old value into bit 0. While `rst` is high, S is loaded with `cfg_seed ^ 16'hACE1`, or with 16'h0001 if that XOR is zero.
- R10: Recency is kept per set. A hit or fill makes the touched way the newest. Every way that was newer than the touched way ages by one step. After reset, the ages are ordered by way number, with way 0 the newest.
- R11: Sets are independent: an access changes the lines and ages of its own set only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_policy | input | 2 | Victim policy: 0/3 oldest, 1 newest, 2 random |
| cfg_seed | input | 16 | Seed for the random state, loaded during reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Byte address to look up |
| resp_valid | output | 1 | Response present, one cycle after acceptance |
| resp_status | output | 2 | 0 hit, 1 fill into an empty way, 2 eviction |
| resp_evict_addr | output | ADDR_W | Block base address of the evicted line on status 2, otherwise zero |

## Verification
The assertions rely on two things. First, `rst` is held high for at least one clock edge before any traffic. Second, `cfg_policy` and `req_addr` carry defined values whenever `req_valid` is high, because the repeated-block hit property compares addresses across consecutive accepted requests. The stimulus satisfies both: reset always lasts several cycles, the bench drives every input on the falling edge, and addresses are built from defined tag, set and offset fields. The addresses come from a small pool of tags, so hits, fills and evictions all happen often, under every policy, with idle gaps and back-to-back repeats mixed in.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
   typedef enum logic [1:0] {
      ST_HIT   = 2'd0,
      ST_FILL  = 2'd1,
      ST_EVICT = 2'd2
   } lookup_status_t;

   typedef enum logic [1:0] {
      POL_OLDEST = 2'd0,
      POL_NEWEST = 2'd1,
      POL_RANDOM = 2'd2
   } victim_policy_t;

   localparam int RNG_W = 16;
endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
   parameter int ADDR_W   = 16,
   parameter int SET_BITS = 2,
   parameter int OFF_BITS = 2,
   localparam int TAG_W   = ADDR_W - SET_BITS - OFF_BITS
) (
   input  logic [ADDR_W-1:0]   addr_i,
   output logic [TAG_W-1:0]    tag_o,
   output logic [SET_BITS-1:0] set_o
);
   assign tag_o = addr_i[ADDR_W-1 -: TAG_W];
   assign set_o = addr_i[OFF_BITS +: SET_BITS];
endmodule

// File: rtl/cache_way_match.sv
module cache_way_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 12,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]            valid_i,
   input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
   input  logic [TAG_W-1:0]           tag_i,
   output logic                       hit_o,
   output logic [WAY_W-1:0]           hit_way_o,
   output logic                       free_o,
   output logic [WAY_W-1:0]           free_way_o
);
   logic [WAYS-1:0] match_vec;

   genvar gw;
   generate
      for (gw = 0; gw < WAYS; gw++) begin : g_cmp
         assign match_vec[gw] = valid_i[gw] && (tags_i[gw] == tag_i);
      end
   endgenerate

   always_comb begin
      hit_o      = |match_vec;
      free_o     = ~&valid_i;
      hit_way_o  = '0;
      free_way_o = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match_vec[w]) hit_way_o = WAY_W'(w);
         if (!valid_i[w])  free_way_o = WAY_W'(w);
      end
   end
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel
   import cache_tag_pkg::*;
#(
   parameter int WAYS  = 4,
   localparam int WAY_W = $clog2(WAYS),
   localparam int AGE_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][AGE_W-1:0] ages_i,
   input  logic [1:0]                 policy_i,
   input  logic [RNG_W-1:0]           rand_i,
   output logic [WAY_W-1:0]           victim_o
);
   logic [WAY_W-1:0] oldest_way;
   logic [WAY_W-1:0] newest_way;
   logic [WAY_W-1:0] rand_way;

   generate
      if ((WAYS & (WAYS - 1)) == 0) begin : g_pow2
         assign rand_way = rand_i[WAY_W-1:0];
      end else begin : g_mod
         assign rand_way = WAY_W'(rand_i % RNG_W'(WAYS));
      end
   endgenerate

   always_comb begin
      oldest_way = '0;
      newest_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (ages_i[w] == AGE_W'(WAYS - 1)) oldest_way = WAY_W'(w);
         if (ages_i[w] == '0)               newest_way = WAY_W'(w);
      end
   end

   always_comb begin
      case (policy_i)
         POL_NEWEST: victim_o = newest_way;
         POL_RANDOM: victim_o = rand_way;
         default:    victim_o = oldest_way;
      endcase
   end
endmodule

// File: rtl/cache_lfsr.sv
module cache_lfsr
   import cache_tag_pkg::*;
#(
   parameter logic [RNG_W-1:0] MIX = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [RNG_W-1:0] seed_i,
   input  logic             step_i,
   output logic [RNG_W-1:0] state_o
);
   logic [RNG_W-1:0] q;
   logic [RNG_W-1:0] load_val;
   logic             fb;

   assign load_val = ((seed_i ^ MIX) == '0) ? RNG_W'(1) : (seed_i ^ MIX);
   assign fb       = q[15] ^ q[13] ^ q[12] ^ q[10];

   always_ff @(posedge clk) begin
      if (rst)         q <= load_val;
      else if (step_i) q <= {q[RNG_W-2:0], fb};
   end

   assign state_o = q;
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
   import cache_tag_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int SET_BITS = 2,
   parameter int OFF_BITS = 2,
   parameter int WAYS     = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        cfg_policy,
   input  logic [15:0]       cfg_seed,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              resp_valid,
   output logic [1:0]        resp_status,
   output logic [ADDR_W-1:0] resp_evict_addr
);
   localparam int SETS  = 1 << SET_BITS;
   localparam int TAG_W = ADDR_W - SET_BITS - OFF_BITS;
   localparam int WAY_W = $clog2(WAYS);
   localparam int AGE_W = $clog2(WAYS);

   generate
      if (OFF_BITS < 2) begin : g_bad_off
         $error("cache_tag_dir: OFF_BITS must be at least 2");
      end
      if (SET_BITS < 1) begin : g_bad_set
         $error("cache_tag_dir: SET_BITS must be at least 1");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("cache_tag_dir: ADDR_W leaves no tag bits");
      end
      if (WAYS < 2) begin : g_bad_ways
         $error("cache_tag_dir: WAYS must be at least 2");
      end
   endgenerate

   // directory state
   logic [WAYS-1:0]            valid_q [SETS];
   logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
   logic [WAYS-1:0][AGE_W-1:0] age_q   [SETS];
   logic                       ready_q;

   // lookup path
   logic [TAG_W-1:0]           req_tag;
   logic [SET_BITS-1:0]        req_set;
   logic [WAYS-1:0]            cur_valid;
   logic [WAYS-1:0][TAG_W-1:0] cur_tags;
   logic [WAYS-1:0][AGE_W-1:0] cur_ages;
   logic                       is_hit;
   logic                       has_free;
   logic [WAY_W-1:0]           hit_way;
   logic [WAY_W-1:0]           free_way;
   logic [WAY_W-1:0]           victim_way;
   logic [WAY_W-1:0]           touch_way;
   logic [AGE_W-1:0]           touch_age;
   logic [RNG_W-1:0]           rng_state;
   logic                       accept;
   logic                       evicting;
   logic [1:0]                 next_status;
   logic [ADDR_W-1:0]          next_evict;

   assign req_ready = ready_q;
   assign accept    = req_valid && ready_q;

   cache_addr_split #(
      .ADDR_W  (ADDR_W),
      .SET_BITS(SET_BITS),
      .OFF_BITS(OFF_BITS)
   ) split_i (
      .addr_i(req_addr),
      .tag_o (req_tag),
      .set_o (req_set)
   );

   assign cur_valid = valid_q[req_set];
   assign cur_tags  = tag_q[req_set];
   assign cur_ages  = age_q[req_set];

   cache_way_match #(
      .WAYS (WAYS),
      .TAG_W(TAG_W)
   ) match_i (
      .valid_i   (cur_valid),
      .tags_i    (cur_tags),
      .tag_i     (req_tag),
      .hit_o     (is_hit),
      .hit_way_o (hit_way),
      .free_o    (has_free),
      .free_way_o(free_way)
   );

   cache_victim_sel #(
      .WAYS(WAYS)
   ) victim_i (
      .ages_i  (cur_ages),
      .policy_i(cfg_policy),
      .rand_i  (rng_state),
      .victim_o(victim_way)
   );

   assign evicting = accept && !is_hit && !has_free;

   cache_lfsr rng_i (
      .clk    (clk),
      .rst    (rst),
      .seed_i (cfg_seed),
      .step_i (evicting && (cfg_policy == POL_RANDOM)),
      .state_o(rng_state)
   );

   always_comb begin
      if (is_hit)        touch_way = hit_way;
      else if (has_free) touch_way = free_way;
      else               touch_way = victim_way;
      touch_age = cur_ages[touch_way];
   end

   always_comb begin
      next_evict = '0;
      if (is_hit) begin
         next_status = ST_HIT;
      end else if (has_free) begin
         next_status = ST_FILL;
      end else begin
         next_status = ST_EVICT;
         next_evict  = {cur_tags[victim_way], req_set, {OFF_BITS{1'b0}}};
      end
   end

   // line and recency update
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            tag_q[s]   <= '0;
            for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
         end
      end else if (accept) begin
         if (!is_hit) begin
            valid_q[req_set][touch_way] <= 1'b1;
            tag_q[req_set][touch_way]   <= req_tag;
         end
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)     age_q[req_set][w] <= '0;
            else if (cur_ages[w] < touch_age) age_q[req_set][w] <= cur_ages[w] + AGE_W'(1);
         end
      end
   end

   // response stage
   always_ff @(posedge clk) begin
      if (rst) begin
         ready_q         <= 1'b0;
         resp_valid      <= 1'b0;
         resp_status     <= ST_HIT;
         resp_evict_addr <= '0;
      end else begin
         ready_q    <= 1'b1;
         resp_valid <= accept;
         if (accept) begin
            resp_status     <= next_status;
            resp_evict_addr <= next_evict;
         end
      end
   end
endmodule

// File: rtl/cache_tag_dir_chk.sv
module cache_tag_dir_chk #(
   parameter int ADDR_W   = 16,
   parameter int SET_BITS = 2,
   parameter int OFF_BITS = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              resp_valid,
   input logic [1:0]        resp_status,
   input logic [ADDR_W-1:0] resp_evict_addr
);
   // R1
   ready_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> req_ready);

   // R3
   resp_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
      resp_valid |-> $past(req_valid && req_ready));

   // R6
   status_legal_chk: assert property (@(posedge clk) disable iff (rst)
      resp_valid |-> resp_status != 2'd3);

   // R6
   evict_offset_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (resp_valid && resp_status == 2'd2) |-> resp_evict_addr[OFF_BITS-1:0] == '0);

   // R6
   evict_set_match_chk: assert property (@(posedge clk) disable iff (rst)
      (resp_valid && resp_status == 2'd2) |->
         resp_evict_addr[OFF_BITS +: SET_BITS] == $past(req_addr[OFF_BITS +: SET_BITS]));

   // R6
   no_evict_addr_chk: assert property (@(posedge clk) disable iff (rst)
      (resp_valid && resp_status != 2'd2) |-> resp_evict_addr == '0);

   // R4
   repeat_block_hit_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && $past(req_valid && req_ready) &&
       req_addr[ADDR_W-1:OFF_BITS] == $past(req_addr[ADDR_W-1:OFF_BITS]))
      |=> resp_status == 2'd0);
endmodule

bind cache_tag_dir cache_tag_dir_chk #(
   .ADDR_W  (ADDR_W),
   .SET_BITS(SET_BITS),
   .OFF_BITS(OFF_BITS)
) chk_i (
   .clk            (clk),
   .rst            (rst),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .req_addr       (req_addr),
   .resp_valid     (resp_valid),
   .resp_status    (resp_status),
   .resp_evict_addr(resp_evict_addr)
);

// File: tb/cache_tag_dir_tb_top.sv
`timescale 1ns/1ps
module cache_tag_dir_tb_top;
   localparam int AW = 16;
   localparam int SB = 2;
   localparam int OB = 2;
   localparam int NW = 4;
   localparam int NS = 1 << SB;
   localparam int TW = AW - SB - OB;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    cfg_policy = 2'd0;
   logic [15:0]   cfg_seed = 16'd0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          resp_valid;
   logic [1:0]    resp_status;
   logic [AW-1:0] resp_evict_addr;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   cache_tag_dir #(.ADDR_W(AW), .SET_BITS(SB), .OFF_BITS(OB), .WAYS(NW)) dut_i (
      .clk(clk), .rst(rst), .cfg_policy(cfg_policy), .cfg_seed(cfg_seed),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .resp_valid(resp_valid), .resp_status(resp_status),
      .resp_evict_addr(resp_evict_addr)
   );

   // reference state
   logic          m_val [NS][NW];
   logic [TW-1:0] m_tag [NS][NW];
   int            m_age [NS][NW];
   logic [15:0]   m_rng;

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic model_reset(input logic [15:0] seed);
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++) begin
            m_val[s][w] = 1'b0;
            m_tag[s][w] = '0;
            m_age[s][w] = w;
         end
      m_rng = seed ^ 16'hACE1;
      if (m_rng == 16'h0) m_rng = 16'h0001;
   endtask

   task automatic model_access(input logic [AW-1:0] a, input logic [1:0] pol,
                               output logic [1:0] st, output logic [AW-1:0] ev);
      logic [TW-1:0] t;
      int s, way, old_age;
      t = a[AW-1 -: TW];
      s = int'(a[OB +: SB]);
      way = -1;
      ev = '0;
      for (int w = 0; w < NW; w++) if (m_val[s][w] && m_tag[s][w] == t) way = w;
      if (way >= 0) st = 2'd0;
      else begin
         for (int w = NW - 1; w >= 0; w--) if (!m_val[s][w]) way = w;
         if (way >= 0) st = 2'd1;
         else begin
            st = 2'd2;
            if (pol == 2'd1) begin
               for (int w = 0; w < NW; w++) if (m_age[s][w] == 0) way = w;
            end else if (pol == 2'd2) begin
               way = int'(m_rng % NW);
               m_rng = {m_rng[14:0], m_rng[15] ^ m_rng[13] ^ m_rng[12] ^ m_rng[10]};
            end else begin
               for (int w = 0; w < NW; w++) if (m_age[s][w] == NW - 1) way = w;
            end
            ev = {m_tag[s][way], a[OB +: SB], {OB{1'b0}}};
         end
         m_val[s][way] = 1'b1;
         m_tag[s][way] = t;
      end
      old_age = m_age[s][way];
      for (int w = 0; w < NW; w++)
         if (w == way) m_age[s][w] = 0;
         else if (m_age[s][w] < old_age) m_age[s][w]++;
   endtask

   task automatic do_reset(input logic [15:0] seed);
      @(negedge clk);
      rst = 1'b1;
      req_valid = 1'b0;
      cfg_seed = seed;
      repeat (3) @(negedge clk);
      check("R1 ready low in reset", 32'(req_ready), 32'd0);
      check("R1 resp_valid low in reset", 32'(resp_valid), 32'd0);
      rst = 1'b0;
      model_reset(seed);
      @(negedge clk);
      check("R1 ready after reset", 32'(req_ready), 32'd1);
   endtask

   task automatic access(input logic [AW-1:0] a, input logic [1:0] pol, input string tag);
      logic [1:0] est;
      logic [AW-1:0] eev;
      model_access(a, pol, est, eev);
      req_valid = 1'b1;
      req_addr = a;
      cfg_policy = pol;
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " R3 resp_valid"}, 32'(resp_valid), 32'd1);
      check({tag, " status"}, 32'(resp_status), 32'(est));
      check({tag, " R6 evict addr"}, 32'(resp_evict_addr), 32'(eev));
   endtask

   task automatic idle();
      @(negedge clk);
      check("R3 no response when idle", 32'(resp_valid), 32'd0);
   endtask

   function automatic logic [AW-1:0] mk(input int t, input int s, input int o);
      return {TW'(t), SB'(s), OB'(o)};
   endfunction

   logic [TW-1:0] pool [8];

   initial begin
      pool[0] = 12'h001; pool[1] = 12'h0A5; pool[2] = 12'hFFF; pool[3] = 12'h3C0;
      pool[4] = 12'h800; pool[5] = 12'h123; pool[6] = 12'h7E7; pool[7] = 12'h000;

      do_reset(16'd0);
      idle();
      // R5 fills of set 1 in way order, R2 offset ignored
      access(mk(1, 1, 0), 2'd0, "R5 fill0");
      access(mk(2, 1, 1), 2'd0, "R5 fill1");
      access(mk(3, 1, 2), 2'd0, "R5 fill2");
      access(mk(4, 1, 3), 2'd0, "R5 fill3");
      access(mk(2, 1, 3), 2'd0, "R4 R2 hit other offset");
      check("R4 literal hit code", 32'(resp_status), 32'd0);
      // R11 other set still empty
      access(mk(2, 2, 0), 2'd0, "R11 other set fill");
      check("R11 literal fill code", 32'(resp_status), 32'd1);
      // R7 oldest is tag 1
      access(mk(5, 1, 0), 2'd0, "R7 oldest evict");
      check("R7 literal evict addr", 32'(resp_evict_addr), 32'(mk(1, 1, 0)));
      // R8 newest is tag 5
      access(mk(6, 1, 2), 2'd1, "R8 newest evict");
      check("R8 literal evict addr", 32'(resp_evict_addr), 32'(mk(5, 1, 0)));
      // R10 hit moves tag 3 to newest, then newest eviction takes it
      access(mk(3, 1, 0), 2'd0, "R10 hit");
      access(mk(7, 1, 0), 2'd1, "R10 newest after hit");
      check("R10 literal evict addr", 32'(resp_evict_addr), 32'(mk(3, 1, 0)));
      // R9 random evictions from a nonzero seed
      do_reset(16'h1234);
      for (int i = 0; i < 4; i++) access(mk(16 + i, 3, 0), 2'd2, "R9 fill");
      for (int i = 0; i < 6; i++) access(mk(32 + i, 3, 0), 2'd2, "R9 random evict");
      // R9 seed that XORs to zero
      do_reset(16'hACE1);
      for (int i = 0; i < 4; i++) access(mk(40 + i, 0, 0), 2'd2, "R9 fill z");
      for (int i = 0; i < 4; i++) access(mk(50 + i, 0, 0), 2'd2, "R9 zero-seed evict");
      // policy code 3 behaves as oldest
      access(mk(60, 0, 0), 2'd3, "R7 code3 evict");

      // constrained random phase
      void'($urandom(32'd7734));
      for (int seg = 0; seg < 4; seg++) begin
         do_reset(seg == 0 ? 16'd0 : 16'($urandom));
         for (int i = 0; i < 800; i++) begin
            int r;
            r = int'($urandom % 10);
            if (r == 0) idle();
            else if (r == 1) begin
               logic [AW-1:0] a;
               a = mk(int'(pool[$urandom % 8]), int'($urandom % NS), int'($urandom % 4));
               access(a, 2'($urandom % 4), "R4 repeat first");
               access({a[AW-1:OB], OB'($urandom % 4)}, 2'($urandom % 4), "R4 repeat second");
            end else
               access(mk(int'(pool[$urandom % 8]), int'($urandom % NS), int'($urandom % 4)),
                      2'($urandom % 4), "R10 random access");
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule